// File: doc/BRIEF.md
# Up-Counting Timer with One Compare Channel

This peripheral holds a counter that runs upward from zero, advancing once per prescaled tick. The tick rate is the input clock divided by a power of two. When the count equals a programmable modulo value, the next tick brings it back to zero and raises an overflow flag. A single compare channel watches the count. On the tick that brings the count to the channel's programmed value, the channel raises its own flag. When the channel's interrupt enable is set, that flag drives the interrupt line.

Software reaches every control through a 32-bit register bus with valid/ready handshaking. Write-one-to-clear semantics apply to both flags. The channel flag can be cleared either from its own control register or from a shared status register, which mirrors both flags. A read-only register reports the counter width, so that driver code can adapt to 16-bit or 32-bit builds.

Top module: `cmp_timer`

## Requirements
- R1: After reset, these registers read zero: control (0x00), count (0x04), channel control (0x0C), channel value (0x10) and status (0x1C). The modulo register (0x08) reads all ones of the counter width, and `irq` is low.
- R2: The register at offset 0x20 reads the counter width in bits 23:16, giving 0x00200000 for a 32-bit counter. Writes to it have no effect.
- R3: Control bits 4:3 form the clock-mode field. A value of zero freezes the count. Any nonzero value lets the count advance on each prescaled tick.
- R4: Control bits 2:0 hold a divide exponent d. While counting, a tick occurs every 2^d clock cycles. The first tick comes on the 2^d-th cycle after the enabling write takes effect.
- R5: A tick taken while the count equals the modulo value sets the count to zero and sets control bit 7, the overflow flag. Writing 1 to control bit 7 clears that flag.
- R6: A write of any value to the count register (0x04) sets the count to zero.
- R7: Channel control bits 5:2 hold the channel mode and bit 6 holds the interrupt enable. With a nonzero mode, bit 7, the channel flag, sets on the tick that makes the count equal the channel value register (0x10).
- R8: With a channel mode of zero, matches never set the channel flag.
- R9: Status bit 0 mirrors the channel flag and status bit 8 mirrors the overflow flag. The channel flag clears when 1 is written to channel control bit 7 or to status bit 0. The overflow flag also clears when 1 is written to status bit 8.
- R10: When a channel-flag clear and a new match fall in the same cycle, the flag stays set.
- R11: `irq` is high exactly when the channel flag and the channel interrupt enable are both set.
- R12: `req_ready` is always high. A read accepted on one clock edge returns its data with `rsp_valid` high after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that bus requests use only the listed word offsets. They also assume that each request is a single-cycle pulse with the request fields stable while it is high. The bench's write and read tasks drive each request for exactly one cycle, away from the clock edge, and use only the defined offsets.

Before running the count, the stimulus freezes the counter and zeroes it. Because of this, every expected count, flag and wrap follows from the number of enabled cycles alone, so the compare and clear-collision cases can be placed on exact ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned DIV_W = 3;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_MODV  = 8'h08;
  localparam logic [7:0] OFS_CHCS  = 8'h0C;
  localparam logic [7:0] OFS_CHVAL = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h1C;
  localparam logic [7:0] OFS_WIDTH = 8'h20;

  typedef struct packed {
    logic [1:0]       run_mode;
    logic [DIV_W-1:0] div_exp;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  // mask has the low div_i bits set
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i < int'(div_i));
  end

  always_comb begin
    pre_d = pre_q;
    if (en_i) pre_d = pre_q + 1'b1;
    else      pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = en_i && ((pre_q & mask) == mask);

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] modv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  assign at_top = (cnt_q == modv_i);

  always_comb begin
    cnt_d = cnt_q;
    if (zero_i)      cnt_d = '0;
    else if (tick_i) cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign wrap_o     = tick_i && !zero_i && at_top;

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !zero_i) |=> $stable(cnt_q));
  assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_we,
  input  logic             val_we,
  input  logic             st_we,
  input  logic [31:0]      wdata,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic [3:0]       mode_o,
  output logic             ie_o,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [3:0]       mode_q, mode_d;
  logic             ie_q, ie_d, flag_q, flag_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             hit, wipe;

  assign hit  = tick_i && (mode_q != 4'd0) && (cnt_next_i == val_q);
  assign wipe = (cs_we && wdata[7]) || (st_we && wdata[0]);

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    val_d  = val_q;
    if (cs_we) begin
      mode_d = wdata[5:2];
      ie_d   = wdata[6];
    end
    if (val_we) val_d = wdata[CNT_W-1:0];
    flag_d = flag_q;
    if (hit)       flag_d = 1'b1;
    else if (wipe) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ie_q   <= 1'b0;
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      val_q  <= val_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;

  assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  assert_match_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wipe) |=> flag_q);
  assert_off_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(mode_q) != 4'd0));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq
);
  import tmr_pkg::*;

  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic wr, rd;
  assign req_ready = 1'b1;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             tof_q, tof_d;
  logic [CNT_W-1:0] modv_q, modv_d;
  logic             tick, wrap, zero_cnt;
  logic [CNT_W-1:0] cnt, cnt_next, ch_val;
  logic [3:0]       ch_mode;
  logic             ch_ie, ch_flag;

  assign zero_cnt = wr && (req_addr == OFS_COUNT);

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .en_i(ctrl_q.run_mode != 2'b00),
    .div_i(ctrl_q.div_exp), .tick_o(tick));

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick_i(tick), .zero_i(zero_cnt),
    .modv_i(modv_q), .cnt_o(cnt), .cnt_next_o(cnt_next), .wrap_o(wrap));

  tmr_channel #(.CNT_W(CNT_W)) u_ch0 (
    .clk(clk), .rst_n(rst_s_n),
    .cs_we(wr && (req_addr == OFS_CHCS)),
    .val_we(wr && (req_addr == OFS_CHVAL)),
    .st_we(wr && (req_addr == OFS_STAT)),
    .wdata(req_wdata), .tick_i(tick), .cnt_next_i(cnt_next),
    .mode_o(ch_mode), .ie_o(ch_ie), .val_o(ch_val),
    .flag_o(ch_flag), .irq_o(irq));

  always_comb begin
    ctrl_d = ctrl_q;
    modv_d = modv_q;
    tof_d  = tof_q;
    if (wr && (req_addr == OFS_CTRL)) begin
      ctrl_d.run_mode = req_wdata[4:3];
      ctrl_d.div_exp  = req_wdata[DIV_W-1:0];
      if (req_wdata[7]) tof_d = 1'b0;
    end
    if (wr && (req_addr == OFS_STAT) && req_wdata[8]) tof_d = 1'b0;
    if (wrap) tof_d = 1'b1;
    if (wr && (req_addr == OFS_MODV)) modv_d = req_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0;
      tof_q  <= 1'b0;
      modv_q <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      tof_q  <= tof_d;
      modv_q <= modv_d;
    end
  end

  logic [31:0] rdata_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    rdata_d = '0;
    case (req_addr)
      OFS_CTRL:  rdata_d = {24'd0, tof_q, 2'b00, ctrl_q.run_mode, ctrl_q.div_exp};
      OFS_COUNT: rdata_d = 32'(cnt);
      OFS_MODV:  rdata_d = 32'(modv_q);
      OFS_CHCS:  rdata_d = {24'd0, ch_flag, ch_ie, ch_mode, 2'b00};
      OFS_CHVAL: rdata_d = 32'(ch_val);
      OFS_STAT:  rdata_d = {23'd0, tof_q, 7'd0, ch_flag};
      OFS_WIDTH: rdata_d = {8'd0, 8'(CNT_W), 16'd0};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd |=> rsp_valid);
  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    wrap |=> tof_q);
endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

  // {div exponent, modulo, idle cycles}
  localparam logic [55:0] VEC [5] = '{
    {8'd0, 32'd100,        16'd18},
    {8'd3, 32'hFFFF_FFFF,  16'd62},
    {8'd1, 32'd4,          16'd10},
    {8'd7, 32'd3,          16'd254},
    {8'd2, 32'd1,          16'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R12: rsp_valid got %b expected 1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic run_for(input int k);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h08);
    repeat (k) @(negedge clk);
    wr(8'h00, 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R12 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h04, v); chk("R1 count", v, 32'h0);
    rd(8'h08, v); chk("R1 modulo", v, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R1 chcs", v, 32'h0);
    rd(8'h10, v); chk("R1 chval", v, 32'h0);
    rd(8'h1C, v); chk("R1 status", v, 32'h0);
    rd(8'h20, v); chk("R2 width", v, 32'h0020_0000);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R2 write ignored", v, 32'h0020_0000);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 5; i++) begin
      int d; longint m, t; int k;
      d = int'(VEC[i][55:48]); m = longint'(VEC[i][47:16]); k = int'(VEC[i][15:0]);
      wr(8'h00, 32'h80);
      wr(8'h08, VEC[i][47:16]);
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h08 | 32'(d));
      repeat (k) @(negedge clk);
      wr(8'h00, 32'h00);
      t = longint'((k + 2) >> d);
      rd(8'h04, v); chk("R4 count", v, 32'(t % (m + 1)));
      rd(8'h00, v); chk("R5 overflow", v, (t > m) ? 32'h80 : 32'h0);
      repeat (3) @(negedge clk);
      rd(8'h04, v); chk("R3 frozen", v, 32'(t % (m + 1)));
    end

    // R9 overflow mirror and clear from status
    rd(8'h1C, v); chk("R9 tof mirror", v, 32'h100);
    wr(8'h1C, 32'h100);
    rd(8'h00, v); chk("R9 tof clear", v, 32'h0);
    // R5 clear via control bit 7
    wr(8'h08, 32'd0); run_for(2);
    rd(8'h00, v); chk("R5 set again", v, 32'h80);
    wr(8'h00, 32'h80);
    rd(8'h00, v); chk("R5 w1c", v, 32'h0);

    // R6 count write zeroes
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, 32'h08); repeat (5) @(negedge clk); wr(8'h00, 32'h0);
    wr(8'h04, 32'h1234);
    rd(8'h04, v); chk("R6 zeroed", v, 32'h0);

    // R7 R11 compare with interrupt
    wr(8'h10, 32'd5);
    wr(8'h0C, 32'h50);
    run_for(10);
    rd(8'h0C, v); chk("R7 flag", v, 32'hD0);
    chk("R11 irq high", {31'd0, irq}, 32'd1);
    rd(8'h1C, v); chk("R9 flag mirror", v, 32'h1);
    wr(8'h1C, 32'h1);
    rd(8'h0C, v); chk("R9 status clear", v, 32'h50);
    chk("R11 irq low", {31'd0, irq}, 32'd0);
    run_for(10);
    wr(8'h0C, 32'hD0);
    rd(8'h0C, v); chk("R9 chcs clear", v, 32'h50);

    // R8 mode zero
    wr(8'h0C, 32'h40);
    run_for(10);
    rd(8'h0C, v); chk("R8 no flag", v, 32'h40);
    chk("R8 irq", {31'd0, irq}, 32'd0);

    // R11 enable off
    wr(8'h0C, 32'h10);
    run_for(10);
    rd(8'h0C, v); chk("R7 flag no ie", v, 32'h90);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);

    // R10 clear colliding with match (modulo 3, value 2, match every 4 ticks)
    wr(8'h08, 32'd3); wr(8'h10, 32'd2); wr(8'h0C, 32'h90);
    wr(8'h04, 32'h0); wr(8'h00, 32'h08);
    repeat (4) @(negedge clk);
    wr(8'h0C, 32'h90);
    wr(8'h00, 32'h00);
    rd(8'h0C, v); chk("R10 match wins", v, 32'h90);
    wr(8'h0C, 32'h90);
    wr(8'h04, 32'h0); wr(8'h00, 32'h08);
    repeat (5) @(negedge clk);
    wr(8'h0C, 32'h90);
    wr(8'h00, 32'h00);
    rd(8'h0C, v); chk("R10 clear alone", v, 32'h10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule